// File: doc/BRIEF.md
# Serial Byte Transmitter with Low Finishing Bit

This block serialises one byte at a time onto a single output line. The line rests high. When an upstream agent offers a byte while the transmitter is idle, the block sends a low start bit and then the eight data bits, least significant first. It ends the frame with a finishing bit that is driven **low**, not with the usual high stop bit. Each bit is held on the line for a fixed number of clock cycles, set by a parameter equal to the clock frequency divided by the baud rate.

A readiness output tells the upstream agent when the transmitter will take a byte. The agent is typically a lock-holding controller that arbitrates between several producers. An optional clear-to-send input, enabled by a parameter, holds back the start of a frame until the far end allows it. After the finishing bit the line stays high for one full bit period before another frame can begin, so the receiver sees a clean falling edge on the next start bit.

Top module: `lowstop_serial_tx`

## Requirements
- R1: After reset the transmitter is idle, `serial_out` is 1 and `tx_ready` is 1.
- R2: While idle and no byte is accepted, `serial_out` stays 1.
- R3: A frame on `serial_out` is ten bit periods: start bit 0, then `tx_data[0]` through `tx_data[7]` in that order, then a finishing bit 0.
- R4: Every bit period of a frame lasts exactly `TICKS_PER_BIT` clock cycles. The start bit begins on the clock edge that accepts the byte.
- R5: For byte 0x2A the line carries 0,0,1,0,1,0,1,0,0,0 and then returns to 1.
- R6: `tx_ready` is 1 only while the transmitter is idle. It is 0 from the cycle after an accepting edge until the frame and its idle gap are over.
- R7: A byte is captured only on an edge where `tx_valid` and `tx_ready` are both 1 and sending is allowed. A `tx_valid` pulse during a frame has no effect on the line.
- R8: With `USE_CTS`=1, no frame starts while `cts` is 0, and `tx_ready` stays 1 during that time. With `USE_CTS`=0, `cts` is ignored.
- R9: After the finishing bit the line stays 1 for exactly one bit period with `tx_ready` at 0. `tx_ready` returns to 1 `11*TICKS_PER_BIT` edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offer strobe |
| cts | input | 1 | Clear to send from the receiver (used when `USE_CTS`=1) |
| serial_out | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |

## Verification
Counting the clock edge that accepts a byte as edge 0, bit k of the frame is on the line after edges k*T through (k+1)*T-1. The idle gap covers edges 10T through 11T-1, and `tx_ready` rises after edge 11T. The bench therefore numbers every falling edge after the accepting edge. It computes the expected line level and readiness from that number alone, and samples on the falling edge so that each value has settled a half cycle after the edge that produced it. The clear-to-send stall and the busy-time strobes are checked the same way, cycle by cycle, at the ports.

// File: rtl/lstx_pkg.sv
// Shared definitions for the low-finishing-bit serial transmitter.
// Assumes a fixed eight-bit payload per frame.
package lstx_pkg;
    localparam int unsigned LSTX_DATA_W = 8;
    localparam int unsigned LSTX_IDX_W  = $clog2(LSTX_DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_SEND  = 2'd2,
        ST_TAIL  = 2'd3
    } lstx_state_e;
endpackage

// File: rtl/lstx_bit_timer.sv
// Bit-period timer: counts clock cycles while run_i is high and flags the
// last cycle of each period. Assumes TICKS_PER_BIT >= 1; it restarts from
// zero whenever run_i is low or a period ends.
module lstx_bit_timer #(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic period_end_o
);
    localparam int unsigned CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] tick_q;

    // Last cycle of the current bit period.
    assign period_end_o = run_i && (tick_q == LAST_TICK);

    // Advance the tick count, wrapping at period end or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!run_i || period_end_o) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/lstx_frame_ctrl.sv
// Frame sequencer: walks idle -> start -> eight data bits -> low finishing
// bit -> one idle-gap period. Assumes period_end_i comes from a timer that
// runs whenever timer_run_o is high. Readiness is offered only while idle
// with the gap finished.
module lstx_frame_ctrl
    import lstx_pkg::*;
#(
    parameter bit USE_CTS = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_i,
    input  logic                  cts_i,
    input  logic                  period_end_i,
    output lstx_state_e           state_o,
    output logic [LSTX_IDX_W-1:0] idx_o,
    output logic                  ready_o,
    output logic                  accept_o,
    output logic                  timer_run_o
);
    localparam logic [LSTX_IDX_W-1:0] LAST_IDX = LSTX_IDX_W'(LSTX_DATA_W - 1);

    lstx_state_e           state_q;
    logic [LSTX_IDX_W-1:0] idx_q;
    logic                  gap_q;
    logic                  send_ok;

    // Flow-control permission; constant 1 when the parameter disables it.
    assign send_ok     = USE_CTS ? cts_i : 1'b1;
    // Readiness and capture strobe.
    assign ready_o     = (state_q == ST_IDLE) && !gap_q;
    assign accept_o    = valid_i && ready_o && send_ok;
    // Timer runs through the frame and the trailing idle gap.
    assign timer_run_o = (state_q != ST_IDLE) || gap_q;
    assign state_o     = state_q;
    assign idx_o       = idx_q;

    // Frame state, bit index and idle-gap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            gap_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (gap_q) begin
                        if (period_end_i) gap_q <= 1'b0;
                    end else if (accept_o) begin
                        state_q <= ST_START;
                    end
                end
                ST_START: begin
                    if (period_end_i) begin
                        state_q <= ST_SEND;
                        idx_q   <= '0;
                    end
                end
                ST_SEND: begin
                    if (period_end_i) begin
                        if (idx_q == LAST_IDX) state_q <= ST_TAIL;
                        else                   idx_q   <= idx_q + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (period_end_i) begin
                        state_q <= ST_IDLE;
                        gap_q   <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lstx_line_drive.sv
// Line driver: holds the accepted byte and decodes the line level from the
// sequencer state. Assumes accept_i only pulses while the sequencer is idle.
module lstx_line_drive
    import lstx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept_i,
    input  logic [LSTX_DATA_W-1:0] data_i,
    input  lstx_state_e            state_i,
    input  logic [LSTX_IDX_W-1:0]  idx_i,
    output logic [LSTX_DATA_W-1:0] held_o,
    output logic                   serial_o
);
    logic [LSTX_DATA_W-1:0] byte_q;

    // Capture the payload on an accepting edge only.
    always_ff @(posedge clk) begin
        if (!rst_n)        byte_q <= '0;
        else if (accept_i) byte_q <= data_i;
    end

    // Line level per state: idle high, start and finishing bits low.
    always_comb begin
        unique case (state_i)
            ST_IDLE:  serial_o = 1'b1;
            ST_START: serial_o = 1'b0;
            ST_SEND:  serial_o = byte_q[idx_i];
            ST_TAIL:  serial_o = 1'b0;
            default:  serial_o = 1'b1;
        endcase
    end

    assign held_o = byte_q;
endmodule

// File: rtl/lowstop_serial_tx.sv
// Top level of the serial byte transmitter with a low finishing bit.
// Assumes the upstream agent offers a byte only when tx_ready is high;
// offers at other times are ignored. TICKS_PER_BIT = clock / baud.
module lowstop_serial_tx
    import lstx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter bit          USE_CTS       = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LSTX_DATA_W-1:0] tx_data,
    input  logic                   tx_valid,
    input  logic                   cts,
    output logic                   serial_out,
    output logic                   tx_ready
);
    lstx_state_e            st;
    logic [LSTX_IDX_W-1:0]  bit_idx;
    logic [LSTX_DATA_W-1:0] held_byte;
    logic                   accept;
    logic                   timer_run;
    logic                   period_end;

    lstx_bit_timer #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (timer_run),
        .period_end_o(period_end)
    );

    lstx_frame_ctrl #(
        .USE_CTS(USE_CTS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (tx_valid),
        .cts_i       (cts),
        .period_end_i(period_end),
        .state_o     (st),
        .idx_o       (bit_idx),
        .ready_o     (tx_ready),
        .accept_o    (accept),
        .timer_run_o (timer_run)
    );

    lstx_line_drive u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept_i(accept),
        .data_i  (tx_data),
        .state_i (st),
        .idx_i   (bit_idx),
        .held_o  (held_byte),
        .serial_o(serial_out)
    );
endmodule

// File: rtl/lstx_checker.sv
// Property checker for lowstop_serial_tx, attached by bind. Measures each
// bit period with its own counter rather than a parameter-deep delay.
module lstx_checker
    import lstx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter bit          USE_CTS       = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tx_valid,
    input logic                   cts,
    input logic                   tx_ready,
    input logic                   serial_out,
    input lstx_state_e            state,
    input logic [LSTX_IDX_W-1:0]  idx,
    input logic [LSTX_DATA_W-1:0] held
);
    lstx_state_e           prev_state;
    logic [LSTX_IDX_W-1:0] prev_idx;
    int unsigned           seg_cnt;
    logic                  seg_change;

    assign seg_change = (state != prev_state) || (idx != prev_idx);

    // Track how long the current (state, index) segment has lasted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_state <= ST_IDLE;
            prev_idx   <= '0;
            seg_cnt    <= 0;
        end else begin
            prev_state <= state;
            prev_idx   <= idx;
            seg_cnt    <= seg_change ? 0 : seg_cnt + 1;
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> serial_out);                                     // R2
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> !serial_out);                                   // R3
    AST_FINISH_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> !serial_out);                                    // R3
    AST_BIT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_change && prev_state != ST_IDLE) |-> (seg_cnt == TICKS_PER_BIT - 1)); // R4
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (state == ST_IDLE));                                       // R6
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && (cts || !USE_CTS)) |=> (state == ST_START && !tx_ready)); // R7
    AST_BUSY_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(held));       // R7
    AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_CTS && state == ST_IDLE && !cts) |=> (state == ST_IDLE));          // R8
    AST_GAP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_TAIL && state == ST_IDLE) |-> (!tx_ready && serial_out)); // R9
endmodule

bind lowstop_serial_tx lstx_checker #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .USE_CTS      (USE_CTS)
) u_lstx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .cts       (cts),
    .tx_ready  (tx_ready),
    .serial_out(serial_out),
    .state     (st),
    .idx       (bit_idx),
    .held      (held_byte)
);

// File: tb/test_lowstop_serial_tx.sv
// Bench for lowstop_serial_tx: directed corner cases plus seeded random
// bytes. Expected levels come from the frame rule alone.
module test_lowstop_serial_tx;
    localparam int unsigned T = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       cts = 1'b1;
    logic       serial_out;
    logic       tx_ready;

    logic [7:0] n_data = 8'h00;
    logic       n_valid = 1'b0;
    logic       n_serial;
    logic       n_ready;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cyc = 0;

    always #5 clk = ~clk;

    lowstop_serial_tx #(.TICKS_PER_BIT(T), .USE_CTS(1'b1)) i_lowstop_serial_tx (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .cts(cts), .serial_out(serial_out), .tx_ready(tx_ready)
    );

    lowstop_serial_tx #(.TICKS_PER_BIT(T), .USE_CTS(1'b0)) i_lowstop_serial_tx_nocts (
        .clk(clk), .rst_n(rst_n), .tx_data(n_data), .tx_valid(n_valid),
        .cts(1'b0), .serial_out(n_serial), .tx_ready(n_ready)
    );

    // Expected line level for bit slot k of a frame carrying byte b.
    function automatic logic frame_bit(input logic [7:0] b, input int unsigned k);
        if (k == 0 || k == 9) return 1'b0;
        return b[k-1];
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Offer byte b at the current falling edge; accepted at the next rising
    // edge. Check every cycle of the frame and the idle gap after it.
    task automatic send_frame(input logic [7:0] b, input string tag);
        logic exp_s;
        logic exp_r;
        tx_data  = b;
        tx_valid = 1'b1;
        cts      = 1'b1;
        @(posedge clk);
        for (int unsigned j = 0; j <= 11 * T; j++) begin
            @(negedge clk);
            if (j == 0) tx_valid = 1'b0;
            // R7: strobe a different byte mid-frame; it must be ignored.
            if (j == 2 * T) begin tx_valid = 1'b1; tx_data = ~b; end
            if (j == 4 * T) tx_valid = 1'b0;
            exp_s = (j < 10 * T) ? frame_bit(b, j / T) : 1'b1;
            exp_r = (j >= 11 * T);
            if ((j % T == 0) || (j % T == T - 1))
                chk(serial_out == exp_s, "R4", int'(serial_out), int'(exp_s));
            else if (j >= 2 * T && j < 5 * T)
                chk(serial_out == exp_s, "R7", int'(serial_out), int'(exp_s));
            else
                chk(serial_out == exp_s, tag, int'(serial_out), int'(exp_s));
            if (j >= 10 * T)
                chk(tx_ready == exp_r, "R9", int'(tx_ready), int'(exp_r));
            else
                chk(tx_ready == exp_r, "R6", int'(tx_ready), int'(exp_r));
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: values under reset and just after release.
        chk(serial_out == 1'b1, "R1", int'(serial_out), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(serial_out == 1'b1, "R1", int'(serial_out), 1);
        chk(tx_ready == 1'b1, "R1", int'(tx_ready), 1);
        chk(n_serial == 1'b1, "R1", int'(n_serial), 1);

        // R2: idle with no offer keeps the line high.
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(serial_out == 1'b1, "R2", int'(serial_out), 1);
            chk(tx_ready == 1'b1, "R2", int'(tx_ready), 1);
        end

        // R5: directed pattern for 0x2A.
        send_frame(8'h2A, "R5");
        // R3: edge bytes, sent back to back.
        send_frame(8'h00, "R3");
        send_frame(8'hFF, "R3");
        send_frame(8'h80, "R3");
        send_frame(8'h01, "R3");

        // R8: offer held while cts is low; nothing starts, ready stays high.
        tx_data  = 8'hC3;
        tx_valid = 1'b1;
        cts      = 1'b0;
        for (int k = 0; k < int'(3 * T); k++) begin
            @(negedge clk);
            chk(serial_out == 1'b1, "R8", int'(serial_out), 1);
            chk(tx_ready == 1'b1, "R8", int'(tx_ready), 1);
        end
        send_frame(8'hC3, "R8");

        // R3: seeded random bytes.
        for (int k = 0; k < 20; k++) begin
            send_frame(8'($urandom()), "R3");
        end

        // R8: with flow control disabled, cts held at 0 does not block.
        n_data  = 8'hA5;
        n_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        n_valid = 1'b0;
        chk(n_serial == 1'b0, "R8", int'(n_serial), 0);
        chk(n_ready == 1'b0, "R8", int'(n_ready), 0);
        for (int unsigned j = 1; j < 10 * T; j++) begin
            @(negedge clk);
            chk(n_serial == frame_bit(8'hA5, j / T), "R8", int'(n_serial),
                int'(frame_bit(8'hA5, j / T)));
        end
        repeat (T + 1) @(negedge clk);
        chk(n_ready == 1'b1, "R9", int'(n_ready), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule